// File: doc/BRIEF.md
# SDRAM Mode Register and Burst Column Sequencer

This block holds the operating mode of a synchronous DRAM device model or controller. When a mode-register-set load strobe arrives, it checks the 12-bit mode word. A valid word is decoded into burst length, burst order, CAS latency and write-burst policy. A word that uses a reserved code is refused: the block raises an error flag and keeps the previous settings.

Each read or write is started with a one-cycle start pulse that carries a starting column and a write flag. The block then issues one column address per clock until the burst completes. Short bursts wrap inside an aligned block of the burst length, in sequential or interleaved order. A full-page burst walks all 256 columns of a row, wrapping past the top, until a burst stop arrives.

For reads, a data-valid strobe follows every issued column by exactly the programmed CAS latency. Command decoding and bank timing are handled elsewhere.

The burst walker is a two-state machine:
- `ST_IDLE`: no burst is running.
- `ST_RUN`: a burst is issuing addresses.

It has these transitions:
- start: `ST_IDLE` to `ST_RUN`.
- restart: `ST_RUN` to `ST_RUN` on a new start.
- continue: `ST_RUN` to `ST_RUN` while not on the last beat.
- finish: `ST_RUN` to `ST_IDLE` on the last beat.
- stop: `ST_RUN` to `ST_IDLE` on a burst stop.

Top module: `sdram_burst_seq`

## Requirements
- R1: After reset `burst_active`, `rd_valid` and `mode_err` are low. The settings are burst length 1, sequential order, CAS latency 2, and writes following the programmed length.
- R2: Mode word bits [2:0] choose the burst length: 000 gives 1, 001 gives 2, 010 gives 4, 011 gives 8, and 111 gives a full page.
- R3: With bit [3] = 0 (sequential), beat i of a length-L burst from column C is `(C - C mod L) + ((C mod L + i) mod L)`.
- R4: With bit [3] = 1 (interleaved), beat i is `C xor i`, for i below L.
- R5: A full-page burst issues `(C + i) mod 256` and keeps going past 256 beats until stopped.
- R6: When `burst_stop` is high in a cycle that shows an address and `start` is low, that address is the last one. `burst_active` is low in the next cycle.
- R7: Mode word bits [6:4] choose the CAS latency: 010 gives 2 and 011 gives 3. `rd_valid` is high exactly CAS-latency cycles after each cycle that shows a read address, and never for write addresses.
- R8: With bit [9] = 1, a write issues exactly one address while a read still uses the programmed length.
- R9: A load whose word has any of the following is refused: bits [11:10] nonzero, bits [8:7] nonzero, a length code of 100, 101 or 110, code 111 together with bit [3] = 1, or a latency code other than 010 or 011. A refused load sets `mode_err` from the next cycle and leaves the settings unchanged. A valid load clears `mode_err`.
- R10: A start sampled at a clock edge shows beat 0 in the next cycle and one new beat per cycle after that. `burst_active` is high for exactly L cycles.
- R11: A start during a running burst restarts at the new column in the next cycle, and takes priority over a simultaneous `burst_stop`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_load | input | 1 | Mode-register-set strobe |
| mode_word | input | 12 | Mode word captured on `mode_load` |
| start | input | 1 | Burst start pulse |
| start_col | input | 8 | Starting column of the burst |
| start_write | input | 1 | 1 = write burst, 0 = read burst |
| burst_stop | input | 1 | Ends the running burst after the current beat |
| col_addr | output | 8 | Column address of the current beat |
| burst_active | output | 1 | High while `col_addr` carries a beat |
| rd_valid | output | 1 | Read data valid, delayed by the CAS latency |
| mode_err | output | 1 | The last mode load was refused |

## Verification
The assertions assume that `mode_load` is not raised while a burst is running or while read-valid strobes are still in flight, because a latency change would move the pending strobes. The stimulus loads modes only between bursts, after the delay pipe has drained. The assertions also assume that `start` is a single-cycle pulse with stable column and direction. The tasks drive start for one cycle at a falling edge and drop it at the next falling edge. `burst_stop` is asserted only for one cycle inside an active burst.

// File: rtl/sdr_burst_pkg.sv
package sdr_burst_pkg;

    localparam int MODE_W = 12;

    typedef enum logic [2:0] {
        BL_1    = 3'd0,
        BL_2    = 3'd1,
        BL_4    = 3'd2,
        BL_8    = 3'd3,
        BL_PAGE = 3'd7
    } burst_len_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } walk_state_e;

    typedef struct packed {
        burst_len_e blen;
        logic       interleave;
        logic       cl3;
        logic       wr_single;
    } mode_cfg_t;

    localparam mode_cfg_t CFG_RESET = '{blen: BL_1, interleave: 1'b0,
                                        cl3: 1'b0, wr_single: 1'b0};

    function automatic logic word_ok(input logic [MODE_W-1:0] w);
        logic ok;
        ok = 1'b1;
        if (w[11:10] != 2'b00) ok = 1'b0;
        if (w[8:7] != 2'b00) ok = 1'b0;
        case (w[2:0])
            3'b000, 3'b001, 3'b010, 3'b011: ;
            3'b111:  if (w[3]) ok = 1'b0;
            default: ok = 1'b0;
        endcase
        if (w[6:4] != 3'b010 && w[6:4] != 3'b011) ok = 1'b0;
        return ok;
    endfunction

    function automatic mode_cfg_t word_decode(input logic [MODE_W-1:0] w);
        mode_cfg_t c;
        c.blen       = burst_len_e'(w[2:0]);
        c.interleave = w[3];
        c.cl3        = w[4];
        c.wr_single  = w[9];
        return c;
    endfunction

endpackage

// File: rtl/mode_decoder.sv
module mode_decoder
    import sdr_burst_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [MODE_W-1:0] word,
    output mode_cfg_t         cfg,
    output logic              err
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg <= CFG_RESET;
            err <= 1'b0;
        end else if (load) begin
            if (word_ok(word)) begin
                cfg <= word_decode(word);
                err <= 1'b0;
            end else begin
                err <= 1'b1;
            end
        end
    end

    // R9: a refused word leaves the settings untouched and flags the error
    a_r9_reserved_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        load && !word_ok(word) |=> $stable(cfg) && err);

    // R9: an accepted word clears the flag
    a_r9_valid_clears: assert property (@(posedge clk) disable iff (!rst_n)
        load && word_ok(word) |=> !err);

endmodule

// File: rtl/burst_walker.sv
module burst_walker
    import sdr_burst_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  mode_cfg_t        cfg,
    input  logic             start,
    input  logic [COL_W-1:0] start_col,
    input  logic             start_write,
    input  logic             burst_stop,
    output logic [COL_W-1:0] col_addr,
    output logic             burst_active,
    output logic             rd_issue
);

    localparam logic [COL_W-1:0] ALL_ONES = '1;

    walk_state_e      state, state_nx;
    logic [COL_W-1:0] base, cnt, mask;
    logic             full, ilv, is_wr;
    logic             last;
    logic             single;
    logic [COL_W-1:0] mask_new;

    function automatic logic [COL_W-1:0] mask_of(input burst_len_e b);
        logic [COL_W-1:0] m;
        unique case (b)
            BL_1:    m = COL_W'(0);
            BL_2:    m = COL_W'(1);
            BL_4:    m = COL_W'(3);
            BL_8:    m = COL_W'(7);
            default: m = ALL_ONES;
        endcase
        return m;
    endfunction

    assign single   = start_write && cfg.wr_single;
    assign mask_new = single ? COL_W'(0) : mask_of(cfg.blen);
    assign last     = !full && (cnt == mask);

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (start) state_nx = ST_RUN;
            ST_RUN: begin
                if (start)                   state_nx = ST_RUN;
                else if (burst_stop || last) state_nx = ST_IDLE;
                else                         state_nx = ST_RUN;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // burst context: start column, beat counter, length mask, order
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base  <= '0;
            cnt   <= '0;
            mask  <= '0;
            full  <= 1'b0;
            ilv   <= 1'b0;
            is_wr <= 1'b0;
        end else if (start) begin
            base  <= start_col;
            cnt   <= '0;
            mask  <= mask_new;
            full  <= (cfg.blen == BL_PAGE) && !single;
            ilv   <= cfg.interleave;
            is_wr <= start_write;
        end else if (state == ST_RUN) begin
            cnt <= cnt + COL_W'(1);
        end
    end

    // outputs
    always_comb begin
        if (ilv) col_addr = base ^ (cnt & mask);
        else     col_addr = (base & ~mask) | ((base + cnt) & mask);
        burst_active = (state == ST_RUN);
        rd_issue     = (state == ST_RUN) && !is_wr;
    end

    // R6: a stop without a start ends the burst on the next cycle
    a_r6_stop_ends: assert property (@(posedge clk) disable iff (!rst_n)
        burst_active && burst_stop && !start |=> !burst_active);

    // R3: sequential short bursts stay inside their aligned block
    a_r3_seq_block: assert property (@(posedge clk) disable iff (!rst_n)
        burst_active && $past(burst_active) && !$past(start) && !ilv && !full
        |-> ((col_addr ^ $past(col_addr)) & ~mask) == '0);

    // R5: a full-page burst advances by one column per cycle, wrapping
    a_r5_page_step: assert property (@(posedge clk) disable iff (!rst_n)
        burst_active && $past(burst_active) && !$past(start) && full
        |-> col_addr == $past(col_addr) + COL_W'(1));

    // R11: a start always yields an active beat at the new column
    a_r11_restart: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> burst_active && col_addr == $past(start_col));

endmodule

// File: rtl/read_valid_pipe.sv
module read_valid_pipe #(
    parameter int MAX_CL = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cl3,
    input  logic rd_issue,
    output logic rd_valid
);

    logic [MAX_CL:1] stage;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage <= '0;
        else        stage <= {stage[MAX_CL-1:1], rd_issue};
    end

    assign rd_valid = cl3 ? stage[3] : stage[2];

    // R7: every strobe traces back to a read beat at latency 2 or 3
    a_r7_valid_origin: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (!cl3 && $past(rd_issue, 2)) || (cl3 && $past(rd_issue, 3)));

    // R7: every read beat under latency 2 yields a strobe two cycles later
    a_r7_cl2_follow: assert property (@(posedge clk) disable iff (!rst_n)
        rd_issue && !cl3 |=> ##1 (rd_valid || cl3));

endmodule

// File: rtl/sdram_burst_seq.sv
module sdram_burst_seq
    import sdr_burst_pkg::*;
#(
    parameter int COL_W  = 8,
    parameter int MAX_CL = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_load,
    input  logic [11:0]      mode_word,
    input  logic             start,
    input  logic [COL_W-1:0] start_col,
    input  logic             start_write,
    input  logic             burst_stop,
    output logic [COL_W-1:0] col_addr,
    output logic             burst_active,
    output logic             rd_valid,
    output logic             mode_err
);

    mode_cfg_t cfg;
    logic      rd_issue;

    mode_decoder u_dec (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (mode_load),
        .word  (mode_word),
        .cfg   (cfg),
        .err   (mode_err)
    );

    burst_walker #(.COL_W(COL_W)) u_walk (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg          (cfg),
        .start        (start),
        .start_col    (start_col),
        .start_write  (start_write),
        .burst_stop   (burst_stop),
        .col_addr     (col_addr),
        .burst_active (burst_active),
        .rd_issue     (rd_issue)
    );

    read_valid_pipe #(.MAX_CL(MAX_CL)) u_pipe (
        .clk      (clk),
        .rst_n    (rst_n),
        .cl3      (cfg.cl3),
        .rd_issue (rd_issue),
        .rd_valid (rd_valid)
    );

    // R1: nothing is active or valid while in reset
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |-> !burst_active && !rd_valid && !mode_err);

endmodule

// File: tb/test_sdram_burst_seq.sv
module test_sdram_burst_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_load = 1'b0;
    logic [11:0] mode_word = '0;
    logic        start = 1'b0;
    logic [7:0]  start_col = '0;
    logic        start_write = 1'b0;
    logic        burst_stop = 1'b0;
    logic [7:0]  col_addr;
    logic        burst_active;
    logic        rd_valid;
    logic        mode_err;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    sdram_burst_seq i_sdram_burst_seq (
        .clk(clk), .rst_n(rst_n), .mode_load(mode_load), .mode_word(mode_word),
        .start(start), .start_col(start_col), .start_write(start_write),
        .burst_stop(burst_stop), .col_addr(col_addr), .burst_active(burst_active),
        .rd_valid(rd_valid), .mode_err(mode_err)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int exp_addr(input int col, input int i, input int len, input bit ilv);
        if (ilv) return col ^ i;
        return (col - col % len) + (col % len + i) % len;
    endfunction

    task automatic load_mode(input logic [11:0] w, input int exp_err, input string req);
        @(negedge clk);
        mode_load = 1'b1;
        mode_word = w;
        @(negedge clk);
        mode_load = 1'b0;
        check({req, " mode_err"}, int'(mode_err), exp_err);
    endtask

    // len: beats expected; stop_idx >= 0 raises burst_stop on that beat
    task automatic run_burst(input int col, input bit wr, input int len, input bit ilv,
                             input int cl, input int stop_idx, input string req);
        int n;
        n = (stop_idx >= 0) ? stop_idx + 1 : len;
        @(negedge clk);
        start = 1'b1;
        start_col = 8'(col);
        start_write = wr;
        for (int i = 0; i < n + cl + 2; i++) begin
            @(negedge clk);
            start = 1'b0;
            check({req, " active"}, int'(burst_active), int'(i < n));
            if (i < n) check({req, " addr"}, int'(col_addr), exp_addr(col, i, len, ilv) % 256);
            check({req, " R7 rd_valid"}, int'(rd_valid), int'(!wr && i >= cl && i - cl < n));
            burst_stop = (i == stop_idx);
        end
        burst_stop = 1'b0;
    endtask

    task automatic t_reset;
        check("R1 active", int'(burst_active), 0);
        check("R1 rd_valid", int'(rd_valid), 0);
        check("R1 mode_err", int'(mode_err), 0);
        // default settings: BL1, sequential, CL2
        run_burst(8'h33, 1'b0, 1, 1'b0, 2, -1, "R1 R10 default");
    endtask

    task automatic t_sequential;
        load_mode(12'h022, 0, "R2");
        run_burst(8'h0E, 1'b0, 4, 1'b0, 2, -1, "R3 seq4");
        load_mode(12'h023, 0, "R2");
        run_burst(8'h1D, 1'b0, 8, 1'b0, 2, -1, "R3 R10 seq8");
    endtask

    task automatic t_interleaved;
        load_mode(12'h029, 0, "R4");
        run_burst(8'h03, 1'b0, 2, 1'b1, 2, -1, "R4 il2");
        load_mode(12'h03B, 0, "R4");
        run_burst(8'h25, 1'b0, 8, 1'b1, 3, -1, "R4 il8 cl3");
        run_burst(8'h25, 1'b1, 8, 1'b1, 3, -1, "R7 write il8");
    endtask

    task automatic t_page_and_stop;
        load_mode(12'h027, 0, "R5");
        run_burst(8'hFC, 1'b0, 256, 1'b0, 2, 5, "R5 R6 page wrap");
        load_mode(12'h023, 0, "R6");
        run_burst(8'h40, 1'b0, 8, 1'b0, 2, 2, "R6 early stop");
    endtask

    task automatic t_page_long;
        load_mode(12'h027, 0, "R5");
        run_burst(8'h80, 1'b1, 256, 1'b0, 2, 259, "R5 page beyond 256");
    endtask

    task automatic t_single_write;
        load_mode(12'h223, 0, "R8");
        run_burst(8'h10, 1'b1, 1, 1'b0, 2, -1, "R8 write single");
        run_burst(8'h10, 1'b0, 8, 1'b0, 2, -1, "R8 read full length");
    endtask

    task automatic t_reserved;
        load_mode(12'h03B, 0, "R9 base");
        load_mode(12'h0A2, 1, "R9 bits8:7");
        load_mode(12'h034, 1, "R9 len100");
        load_mode(12'h04A, 1, "R9 cl100");
        load_mode(12'h02F, 1, "R9 page+il");
        load_mode(12'h422, 1, "R9 bits11:10");
        run_burst(8'h25, 1'b0, 8, 1'b1, 3, -1, "R9 settings kept");
        load_mode(12'h022, 0, "R9 clear");
        run_burst(8'h0E, 1'b0, 4, 1'b0, 2, -1, "R9 new settings");
    endtask

    task automatic t_restart;
        int exp_a [10];
        load_mode(12'h023, 0, "R11");
        exp_a[0] = 8'h05;
        exp_a[1] = 8'h06;
        for (int k = 0; k < 8; k++) exp_a[k + 2] = 8'h40 + k;
        @(negedge clk);
        start = 1'b1;
        start_col = 8'h05;
        start_write = 1'b0;
        for (int i = 0; i < 14; i++) begin
            @(negedge clk);
            start = 1'b0;
            burst_stop = 1'b0;
            check("R11 active", int'(burst_active), int'(i < 10));
            if (i < 10) check("R11 addr", int'(col_addr), exp_a[i]);
            check("R11 R7 rd_valid", int'(rd_valid), int'(i >= 2 && i < 12));
            if (i == 1) begin
                start = 1'b1;
                start_col = 8'h40;
                burst_stop = 1'b1;
            end
        end
        start = 1'b0;
        burst_stop = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_sequential();
        t_interleaved();
        t_page_and_stop();
        t_page_long();
        t_single_write();
        t_reserved();
        t_restart();
        repeat (4) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule